// File: doc/BRIEF.md
# Mode-Banked General and Status Register File

This block is the architectural register store of a 32-bit RISC core that runs in one of seven operating modes. It keeps thirty stored general-purpose registers, one current status register and five saved status registers. The program counter is the thirty-first general register. It is not stored here: reads of its index are served from the core's fetch address, and writes to it are passed out as a branch request.

The operating mode is the low five bits of the current status register. That mode picks which physical register answers each of the sixteen architectural indices. Fast-interrupt mode has private copies of indices 8 to 14. Every other exception mode has private copies of 13 and 14 only. User and system modes see the same bank. Each exception mode also has its own saved status register, reached through a dedicated port.

There are two combinational read ports and one write port. A read of the index being written in the same cycle returns the new data. The pipeline, the decoder and exception sequencing sit outside this block. They drive the indices, the write strobes and the status writes that switch modes.

Top module: `regbank_top`

## Requirements
- R1: After reset, all stored general and saved status registers read zero, the current status register reads 0x00000013 (supervisor mode), and the mode error flag is low.
- R2: Status bits [4:0] select the mode: 0x10 user, 0x11 fast interrupt, 0x12 normal interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined, 0x1F system. Any other value raises the mode error flag and selects the user bank, with no saved status register.
- R3: Indices 0 to 7 name the same physical registers in every mode.
- R4: Indices 8 to 12 have one private copy for fast-interrupt mode. All other modes share a second copy.
- R5: Indices 13 and 14 have a private copy in each of the five exception modes. User and system modes share one copy.
- R6: Each exception mode has its own saved status register, written and read through the saved-status port. In user or system mode the port reads zero and its writes are ignored.
- R7: When a read index equals the index written in the same cycle, the read returns the write data. The same holds for the saved-status port.
- R8: Reading index 15 returns pc_in plus 8.
- R9: Writing index 15 raises branch_req in that cycle, with branch_target equal to the write data. No stored register changes. At any other time branch_req is low.
- R10: A status write is visible on cur_status from the next cycle. Bank selection within a cycle uses the status value held at the start of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_in | input | 32 | Address of the current instruction |
| rd_a_idx | input | 4 | Architectural index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Architectural index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | General register write strobe |
| wr_idx | input | 4 | Architectural index written |
| wr_data | input | 32 | Write data |
| branch_req | output | 1 | Index 15 is being written |
| branch_target | output | 32 | New program counter when branch_req is high |
| st_wr_en | input | 1 | Current status write strobe |
| st_wr_data | input | 32 | New current status value |
| cur_status | output | 32 | Current status register |
| sv_wr_en | input | 1 | Saved status write strobe for the current mode |
| sv_wr_data | input | 32 | Saved status write data |
| saved_status | output | 32 | Saved status of the current mode, zero in user or system |
| mode_err | output | 1 | Status mode bits hold an unlisted encoding |

## Verification
Two pairs of functions can fall in the same cycle. The first is a general-register write and a read of the same index. The second is a status write that switches the mode while a register access is also under way. The bench places each write so that port A reads the written index in the very cycle of the write, and expects the new data there. For a mode switch, the bench confirms that cur_status still shows the old value during the switching cycle. From the next cycle on, every index is compared against a per-mode model that knows which modes share each register.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int XLEN   = 32;
    localparam int IDXW   = 4;
    localparam int NSLOT  = 30;
    localparam int SLOTW  = $clog2(NSLOT);
    localparam int NSAVED = 5;
    localparam int SAVW   = $clog2(NSAVED);
    localparam logic [IDXW-1:0] PC_IDX = 4'd15;

    typedef enum logic [4:0] {
        MODE_USR = 5'h10,
        MODE_FIQ = 5'h11,
        MODE_IRQ = 5'h12,
        MODE_SVC = 5'h13,
        MODE_ABT = 5'h17,
        MODE_UND = 5'h1B,
        MODE_SYS = 5'h1F
    } mode_e;

    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

    typedef struct packed {
        bank_e bank;
        logic  bad;
    } bank_sel_t;

    // Mode bits to bank; unknown codes fall back to the user bank.
    function automatic bank_sel_t decode_mode(logic [4:0] m);
        bank_sel_t s;
        s.bad = 1'b0;
        case (m)
            MODE_USR, MODE_SYS: s.bank = BANK_USR;
            MODE_FIQ:           s.bank = BANK_FIQ;
            MODE_IRQ:           s.bank = BANK_IRQ;
            MODE_SVC:           s.bank = BANK_SVC;
            MODE_ABT:           s.bank = BANK_ABT;
            MODE_UND:           s.bank = BANK_UND;
            default: begin
                s.bank = BANK_USR;
                s.bad  = 1'b1;
            end
        endcase
        return s;
    endfunction

    // Physical slot layout:
    //   0..7   shared low registers
    //   8..12  indices 8..12 for every bank but fast interrupt
    //   13..17 indices 8..12 for fast interrupt
    //   18..29 indices 13/14, two slots per bank
    function automatic logic [SLOTW-1:0] slot_of(bank_e b, logic [IDXW-1:0] idx);
        logic [SLOTW-1:0] s;
        if (idx < 4'd8) begin
            s = {1'b0, idx};
        end else if (idx < 4'd13) begin
            s = (b == BANK_FIQ) ? SLOTW'(idx) + SLOTW'(5) : SLOTW'(idx);
        end else begin
            s = SLOTW'(18) + {1'b0, b, 1'b0} + {4'b0, idx[1]};
        end
        return s;
    endfunction

endpackage

// File: rtl/regbank_map.sv
module regbank_map
    import regbank_pkg::*;
#(
    parameter int NPORT = 3
) (
    input  bank_e                       bank,
    input  logic [NPORT-1:0][IDXW-1:0]  idx,
    output logic [NPORT-1:0][SLOTW-1:0] slot,
    output logic [NPORT-1:0]            is_pc
);
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign slot[g]  = slot_of(bank, idx[g]);
        assign is_pc[g] = (idx[g] == PC_IDX);
    end
endmodule

// File: rtl/regbank_gpr.sv
module regbank_gpr
    import regbank_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [SLOTW-1:0]          wslot,
    input  logic [XLEN-1:0]           wdata,
    input  logic [NRD-1:0][SLOTW-1:0] rslot,
    output logic [NRD-1:0][XLEN-1:0]  rdata
);
    logic [XLEN-1:0] mem [NSLOT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wslot] <= wdata;
        end
    end

    // Write-first: a matching read in the same cycle sees the new data.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (we && wslot == rslot[g]) ? wdata : mem[rslot[g]];
    end
endmodule

// File: rtl/regbank_status.sv
module regbank_status
    import regbank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bank_e           bank,
    input  logic            st_we,
    input  logic [XLEN-1:0] st_wdata,
    input  logic            sv_we,
    input  logic [XLEN-1:0] sv_wdata,
    output logic [XLEN-1:0] cur,
    output logic [XLEN-1:0] saved
);
    logic [XLEN-1:0] cur_q;
    logic [XLEN-1:0] saved_q [NSAVED];
    logic            has_saved;
    logic [SAVW-1:0] sidx;
    logic            sv_hit;

    assign has_saved = (bank != BANK_USR);
    assign sidx      = SAVW'(3'(bank) - 3'd1);
    assign sv_hit    = sv_we && has_saved;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= {{(XLEN-5){1'b0}}, MODE_SVC};
            for (int i = 0; i < NSAVED; i++) saved_q[i] <= '0;
        end else begin
            if (st_we) cur_q <= st_wdata;
            if (sv_hit) saved_q[sidx] <= sv_wdata;
        end
    end

    assign cur   = cur_q;
    assign saved = !has_saved ? '0 : (sv_hit ? sv_wdata : saved_q[sidx]);
endmodule

// File: rtl/regbank_top.sv
module regbank_top
    import regbank_pkg::*;
#(
    parameter int PC_AHEAD = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] pc_in,
    input  logic [3:0]  rd_a_idx,
    output logic [31:0] rd_a_data,
    input  logic [3:0]  rd_b_idx,
    output logic [31:0] rd_b_data,
    input  logic        wr_en,
    input  logic [3:0]  wr_idx,
    input  logic [31:0] wr_data,
    output logic        branch_req,
    output logic [31:0] branch_target,
    input  logic        st_wr_en,
    input  logic [31:0] st_wr_data,
    output logic [31:0] cur_status,
    input  logic        sv_wr_en,
    input  logic [31:0] sv_wr_data,
    output logic [31:0] saved_status,
    output logic        mode_err
);
    localparam int NRD   = 2;
    localparam int NPORT = NRD + 1;

    bank_sel_t                   sel;
    logic [NPORT-1:0][IDXW-1:0]  idx;
    logic [NPORT-1:0][SLOTW-1:0] slot;
    logic [NPORT-1:0]            is_pc;
    logic [NRD-1:0][SLOTW-1:0]   rslot;
    logic [NRD-1:0][XLEN-1:0]    rdata;
    logic [XLEN-1:0]             pc_view;
    logic                        gpr_we;

    assign sel      = decode_mode(cur_status[4:0]);
    assign mode_err = sel.bad;

    // Ports 0..NRD-1 are reads; port NRD is the write.
    assign idx   = {wr_idx, rd_b_idx, rd_a_idx};
    assign rslot = slot[NRD-1:0];

    regbank_map #(.NPORT(NPORT)) u_map (
        .bank  (sel.bank),
        .idx   (idx),
        .slot  (slot),
        .is_pc (is_pc)
    );

    assign gpr_we = wr_en && !is_pc[NRD];

    regbank_gpr #(.NRD(NRD)) u_gpr (
        .clk   (clk),
        .rst   (rst),
        .we    (gpr_we),
        .wslot (slot[NRD]),
        .wdata (wr_data),
        .rslot (rslot),
        .rdata (rdata)
    );

    regbank_status u_status (
        .clk      (clk),
        .rst      (rst),
        .bank     (sel.bank),
        .st_we    (st_wr_en),
        .st_wdata (st_wr_data),
        .sv_we    (sv_wr_en),
        .sv_wdata (sv_wr_data),
        .cur      (cur_status),
        .saved    (saved_status)
    );

    assign pc_view       = pc_in + XLEN'(PC_AHEAD);
    assign rd_a_data     = is_pc[0] ? pc_view : rdata[0];
    assign rd_b_data     = is_pc[1] ? pc_view : rdata[1];
    assign branch_req    = wr_en && is_pc[NRD];
    assign branch_target = branch_req ? wr_data : '0;
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
    parameter int PC_AHEAD = 8
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_in,
    input logic [3:0]  rd_a_idx,
    input logic [31:0] rd_a_data,
    input logic [3:0]  rd_b_idx,
    input logic [31:0] rd_b_data,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic        branch_req,
    input logic [31:0] branch_target,
    input logic        st_wr_en,
    input logic [31:0] st_wr_data,
    input logic [31:0] cur_status,
    input logic [31:0] saved_status,
    input logic        mode_err
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cur_status == 32'h13 && !mode_err && saved_status == 32'h0));

    a_r2_bad_mode_user_bank: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> saved_status == 32'h0);

    a_r6_no_saved_user_sys: assert property (@(posedge clk) disable iff (rst)
        (cur_status[4:0] == 5'h10 || cur_status[4:0] == 5'h1F) |-> saved_status == 32'h0);

    a_r7_same_cycle_read: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != 4'd15 && rd_b_idx == wr_idx) |-> rd_b_data == wr_data);

    a_r8_pc_view: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == 4'd15) |-> rd_a_data == pc_in + 32'(PC_AHEAD));

    a_r9_branch_on_pc_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == 4'd15) |-> (branch_req && branch_target == wr_data));

    a_r9_no_spurious_branch: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_idx == 4'd15) |-> !branch_req);

    a_r10_status_next_cycle: assert property (@(posedge clk) disable iff (rst)
        st_wr_en |=> cur_status == $past(st_wr_data));
endmodule

bind regbank_top regbank_chk #(.PC_AHEAD(PC_AHEAD)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .pc_in         (pc_in),
    .rd_a_idx      (rd_a_idx),
    .rd_a_data     (rd_a_data),
    .rd_b_idx      (rd_b_idx),
    .rd_b_data     (rd_b_data),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_data       (wr_data),
    .branch_req    (branch_req),
    .branch_target (branch_target),
    .st_wr_en      (st_wr_en),
    .st_wr_data    (st_wr_data),
    .cur_status    (cur_status),
    .saved_status  (saved_status),
    .mode_err      (mode_err)
);

// File: tb/regbank_top_bench.sv
module regbank_top_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] pc_in;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, branch_req, st_wr_en, sv_wr_en, mode_err;
    logic [31:0] branch_target, st_wr_data, cur_status, sv_wr_data, saved_status;

    always #10 clk = ~clk;   // 50 MHz

    regbank_top u_regbank_top (
        .clk(clk), .rst(rst), .pc_in(pc_in),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .branch_req(branch_req), .branch_target(branch_target),
        .st_wr_en(st_wr_en), .st_wr_data(st_wr_data), .cur_status(cur_status),
        .sv_wr_en(sv_wr_en), .sv_wr_data(sv_wr_data), .saved_status(saved_status),
        .mode_err(mode_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model: one view per bank (0 user/system, 1 fiq, 2 irq, 3 svc, 4 abt, 5 und)
    logic [31:0] mdl [6][15];
    logic [31:0] mdl_sv [5];
    logic [31:0] mdl_cur;

    logic [4:0] valid_modes [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};

    function automatic int bank_of(logic [4:0] m);
        case (m)
            5'h11: return 1;
            5'h12: return 2;
            5'h13: return 3;
            5'h17: return 4;
            5'h1B: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_valid(logic [4:0] m);
        foreach (valid_modes[i]) if (valid_modes[i] == m) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit shared(int b1, int b2, int i);
        if (i < 8) return 1'b1;
        if (i < 13) return (b1 == 1) == (b2 == 1);
        return b1 == b2;
    endfunction

    function automatic logic [31:0] exp_read(int i);
        if (i == 15) return pc_in + 32'd8;
        return mdl[bank_of(mdl_cur[4:0])][i];
    endfunction

    function automatic logic [31:0] exp_saved();
        int b = bank_of(mdl_cur[4:0]);
        return (b == 0) ? 32'h0 : mdl_sv[b-1];
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; st_wr_en = 0; sv_wr_en = 0;
        wr_idx = 0; wr_data = 0; st_wr_data = 0; sv_wr_data = 0;
        rd_a_idx = 0; rd_b_idx = 0;
    endtask

    task automatic end_cycle();
        @(posedge clk); #1;
        idle_inputs();
    endtask

    task automatic do_write(int i, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = 4'(i); wr_data = d; rd_a_idx = 4'(i);
        pc_in = $urandom;
        #2;
        if (i == 15) begin
            chk(branch_req && branch_target == d, "R9 branch on pc write", branch_target, d);
            chk(rd_a_data == pc_in + 32'd8, "R8 pc view during pc write", rd_a_data, pc_in + 32'd8);
        end else begin
            chk(rd_a_data == d, "R7 same-cycle write/read", rd_a_data, d);
            chk(!branch_req, "R9 no branch on normal write", 32'(branch_req), 32'h0);
        end
        if (i != 15) begin
            int b = bank_of(mdl_cur[4:0]);
            for (int k = 0; k < 6; k++) if (shared(b, k, i)) mdl[k][i] = d;
        end
        end_cycle();
    endtask

    task automatic read_chk(int i, string req);
        logic [31:0] e;
        @(negedge clk);
        rd_b_idx = 4'(i);
        pc_in = $urandom;
        #2;
        e = exp_read(i);
        chk(rd_b_data == e, req, rd_b_data, e);
    endtask

    task automatic set_mode(logic [4:0] m);
        logic [31:0] old = mdl_cur;
        logic [31:0] nv = {27'h0, m};
        @(negedge clk);
        st_wr_en = 1; st_wr_data = nv;
        #2;
        chk(cur_status == old, "R10 status unchanged in write cycle", cur_status, old);
        end_cycle();
        mdl_cur = nv;
        chk(cur_status == nv, "R10 status after write", cur_status, nv);
        chk(mode_err == !is_valid(m), "R2 mode error flag", 32'(mode_err), 32'(!is_valid(m)));
    endtask

    task automatic sv_write(logic [31:0] d);
        int b = bank_of(mdl_cur[4:0]);
        logic [31:0] e = (b == 0) ? 32'h0 : d;
        @(negedge clk);
        sv_wr_en = 1; sv_wr_data = d;
        #2;
        chk(saved_status == e, "R6/R7 saved status write", saved_status, e);
        if (b != 0) mdl_sv[b-1] = d;
        end_cycle();
    endtask

    task automatic saved_chk(string req);
        @(negedge clk); #2;
        chk(saved_status == exp_saved(), req, saved_status, exp_saved());
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        report();
    end

    initial begin
        void'($urandom(32'd4711));
        idle_inputs();
        pc_in = 32'h0;
        rst = 1;
        for (int k = 0; k < 6; k++) for (int i = 0; i < 15; i++) mdl[k][i] = '0;
        for (int k = 0; k < 5; k++) mdl_sv[k] = '0;
        mdl_cur = 32'h13;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        #2;
        chk(cur_status == 32'h13, "R1 reset status", cur_status, 32'h13);
        chk(!mode_err, "R1 reset mode_err", 32'(mode_err), 32'h0);
        chk(saved_status == 32'h0, "R1 reset saved status", saved_status, 32'h0);
        for (int i = 0; i < 15; i++) read_chk(i, "R1 reset register zero");

        // R8 pc view
        read_chk(15, "R8 pc read");

        // Directed banking: fill every index in supervisor mode
        for (int i = 0; i < 15; i++) do_write(i, 32'hA000_0000 + i);
        set_mode(5'h12);
        read_chk(3, "R3 low reg shared into irq");
        read_chk(10, "R4 irq shares 8-12 with svc");
        read_chk(13, "R5 irq private r13");
        read_chk(14, "R5 irq private r14");
        set_mode(5'h11);
        read_chk(8, "R4 fiq private r8");
        read_chk(12, "R4 fiq private r12");
        do_write(9, 32'hF1F1_0009);
        set_mode(5'h10);
        read_chk(9, "R4 user unaffected by fiq r9 write");
        do_write(13, 32'h0000_5513);
        set_mode(5'h1F);
        read_chk(13, "R5 system shares r13 with user");
        sv_write(32'hDEAD_0001);
        saved_chk("R6 system saved reads zero");
        set_mode(5'h17);
        sv_write(32'h0000_0ABC);
        saved_chk("R6 abort saved status");
        set_mode(5'h1B);
        saved_chk("R6 undefined saved status separate");

        // R2 unlisted encoding behaves as user bank
        set_mode(5'h00);
        read_chk(13, "R2 bad mode reads user bank");
        saved_chk("R2 bad mode saved zero");

        // R9 pc write changes nothing
        do_write(15, 32'h0000_8000);
        for (int i = 0; i < 15; i++) read_chk(i, "R9 no register change on pc write");

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int op = $urandom_range(0, 9);
            if (op <= 3) begin
                int i = ($urandom_range(0, 15) == 0) ? 15 : $urandom_range(0, 14);
                do_write(i, $urandom);
            end else if (op <= 6) begin
                int i = $urandom_range(0, 15);
                if (i < 8) read_chk(i, "R3 random read");
                else if (i < 13) read_chk(i, "R4 random read");
                else if (i < 15) read_chk(i, "R5 random read");
                else read_chk(i, "R8 random pc read");
            end else if (op == 7) begin
                if ($urandom_range(0, 7) == 0) set_mode(5'h15);
                else set_mode(valid_modes[$urandom_range(0, 6)]);
            end else if (op == 8) begin
                sv_write($urandom);
            end else begin
                saved_chk("R6 random saved read");
            end
        end

        // Final sweep in every mode
        foreach (valid_modes[m]) begin
            set_mode(valid_modes[m]);
            for (int i = 0; i < 15; i++) read_chk(i, "R3 R4 R5 final sweep");
            saved_chk("R6 final sweep");
        end

        report();
    end
endmodule